// File: doc/BRIEF.md
# Phase-Staggered Multi-Port PWM Generator

This block drives a set of output ports (nine by default) with pulse-width waveforms built from one shared timing clock. An enable pulse marks each cycle of the timing clock. A prescaler divides these enables by a fixed ratio (32 by default) to form a PWM step. A 5-bit step counter runs through a 32-step period. Each port holds an 8-bit setting word. The word either selects a duty from 0/32 to 31/32 or forces the port to a static high level.

The ports do not all switch together. Port `i` begins its period when the shared counter equals `4 * (i mod 8)`, so the rising edges fall in eighths of the period. Port 8 therefore shares its phase with port 0. Each port runs a small controller with three states: `LANE_LOW` (static low), `LANE_HIGH` (static high) and `LANE_PWM` (duty-driven). The only transition is "period entry". On the step at which a port's local phase returns to zero, the state and duty are reloaded from that port's setting word. Between entries, changes to the word are held off, so a waveform never changes in the middle of a period. A synchronous clear request, gated by an enable input, zeroes the prescaler and the counter. This lets several generators be aligned to one event.

Top module: `stagger_pwm`

## Requirements
- R1: After `rst_n` is asserted (active low), every bit of `pwm_out` is 0 and every port is in `LANE_LOW` until its first period entry.
- R2: The step counter advances once for every `PRESCALE` cycles on which `tick_en` is 1. Cycles with `tick_en` at 0 change neither the prescaler nor the counter.
- R3: The period has 32 steps. After step 31 the counter wraps to 0, so a port's waveform repeats every 32 steps.
- R4: A setting word whose bits [7:4] are not 0111 and whose bits [4:0] are 00000 holds the port low for the whole period.
- R5: A setting word whose bits [7:4] are not 0111 and whose bits [4:0] hold a value d from 1 to 31 makes the port high while its local phase is below d. The output is therefore high for d of the 32 steps, starting at the port's period entry.
- R6: A setting word whose bits [7:4] equal 0111 holds the port high for the whole period, whatever bits [3:0] contain.
- R7: Port `i` has a local phase equal to (counter − 4·(i mod 8)) mod 32, and it reaches its period entry when that phase is 0. Ports 0 and 8 share a phase.
- R8: A change to a port's setting word takes effect only at that port's next period entry. Changes made inside a period leave that period's waveform unchanged.
- R9: When `cnt_clr_req` and `clr_allow` are both 1 at a clock edge, the prescaler and the counter go to 0 at that edge. Ports whose offset is 0 perform a period entry at that edge. When `clr_allow` is 0, the request is ignored.
- R10: Outside the 0111 pattern, bits [7:5] do not affect the duty.
- R11: `pwm_out` is registered and changes only at the clock edge where a step occurs or a clear takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse for each timing-clock cycle |
| cnt_clr_req | input | 1 | Synchronous request to clear the prescaler and the step counter |
| clr_allow | input | 1 | Set to 1 to let `cnt_clr_req` take effect |
| port_cfg | input | NUM_PORTS*8 | Setting words; port i uses bits [8i+7:8i] |
| pwm_out | output | NUM_PORTS | Registered port outputs |

## Verification
The bench sweeps every duty code across all ports with a small prescaler. It then targets the corner cases where this block tends to go wrong:
- **Static-high pattern.** All sixteen 0111 words are tested. A decoder that checks only bit 4 would produce 16+ step pulses instead of a constant high.
- **Upper bits.** Words with stray bits [7:5] are tested. A design that uses all eight bits would overflow the duty compare.
- **Mid-period writes.** Setting words change at arbitrary cycles. A design without a per-port entry latch would cut pulses short or stretch them.
- **Counter clear.** Clears are issued with and without `clr_allow`. Ignoring the enable, or failing to realign the phase, shows up as shifted waveforms.
- **Sparse enables.** Irregular `tick_en` patterns catch a prescaler that counts clocks instead of enables.
- **Stagger.** A duty-4 stagger test counts the active ports at each step. Wrong offsets show up as two or more groups high together.

// File: rtl/stagger_pwm_pkg.sv
package stagger_pwm_pkg;

    localparam int PWM_CODE_W = 5;

    typedef enum logic [1:0] {
        LANE_LOW  = 2'd0,
        LANE_HIGH = 2'd1,
        LANE_PWM  = 2'd2
    } lane_mode_e;

    typedef struct packed {
        lane_mode_e             mode;
        logic [PWM_CODE_W-1:0]  duty;
    } lane_set_t;

    function automatic lane_set_t decode_setting(input logic [7:0] word);
        lane_set_t s;
        if (word[7:4] == 4'b0111) begin
            s.mode = LANE_HIGH;
            s.duty = '0;
        end else if (word[PWM_CODE_W-1:0] == '0) begin
            s.mode = LANE_LOW;
            s.duty = '0;
        end else begin
            s.mode = LANE_PWM;
            s.duty = word[PWM_CODE_W-1:0];
        end
        return s;
    endfunction

endpackage

// File: rtl/pwm_step_timer.sv
module pwm_step_timer #(
    parameter int PRESCALE = 32,
    parameter int CW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          clr,
    output logic          adv,
    output logic [CW-1:0] nxt
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre;
    logic [CW-1:0] cnt;
    logic          wrap_pre;

    assign wrap_pre = tick_en && (pre == PRE_LAST);
    assign adv      = clr || wrap_pre;
    assign nxt      = clr ? '0 : cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
            cnt <= '0;
        end else if (clr) begin
            pre <= '0;
            cnt <= '0;
        end else if (tick_en) begin
            if (wrap_pre) begin
                pre <= '0;
                cnt <= nxt;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    // R2: without enable or clear, the timing state holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clr) |=> ($stable(cnt) && $stable(pre)));

    // R3: counter wraps from the last step to zero
    a_r3_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_pre && !clr && cnt == {CW{1'b1}}) |=> (cnt == '0));

    // R9: an honoured clear leaves both counters at zero
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && pre == '0));

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
    import stagger_pwm_pkg::*;
#(
    parameter int OFFSET = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic [PWM_CODE_W-1:0] nxt,
    input  logic [7:0]            cfg,
    output logic                  pwm
);
    localparam logic [PWM_CODE_W-1:0] OFS = PWM_CODE_W'(OFFSET);

    lane_set_t             cur;
    lane_set_t             nxt_set;
    logic [PWM_CODE_W-1:0] ph;
    logic                  entry;

    assign ph    = nxt - OFS;
    assign entry = adv && (ph == '0);

    always_comb begin
        nxt_set = cur;
        if (entry) nxt_set = decode_setting(cfg);
    end

    // state register: mode and duty, reloaded only at period entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur.mode <= LANE_LOW;
            cur.duty <= '0;
        end else begin
            cur <= nxt_set;
        end
    end

    // output register: updated on every step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else if (adv) begin
            unique case (nxt_set.mode)
                LANE_LOW:  pwm <= 1'b0;
                LANE_HIGH: pwm <= 1'b1;
                LANE_PWM:  pwm <= (ph < nxt_set.duty);
            endcase
        end
    end

    // R4: static-low state never shows a high output
    a_r4_low_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.mode == LANE_LOW) |-> !pwm);

    // R6: static-high state always shows a high output
    a_r6_high_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.mode == LANE_HIGH) |-> pwm);

    // R8: setting changes only at period entry
    a_r8_entry_only: assert property (@(posedge clk) disable iff (!rst_n)
        !entry |=> $stable(cur));

    // R11: output moves only on a step or clear
    a_r11_step_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pwm));

endmodule

// File: rtl/stagger_pwm.sv
module stagger_pwm
    import stagger_pwm_pkg::*;
#(
    parameter int NUM_PORTS    = 9,
    parameter int PRESCALE     = 32,
    parameter int PHASE_GROUPS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   cnt_clr_req,
    input  logic                   clr_allow,
    input  logic [NUM_PORTS*8-1:0] port_cfg,
    output logic [NUM_PORTS-1:0]   pwm_out
);
    localparam int STEPS      = 1 << PWM_CODE_W;
    localparam int PHASE_STEP = STEPS / PHASE_GROUPS;

    logic                  clr;
    logic                  adv;
    logic [PWM_CODE_W-1:0] nxt;

    assign clr = cnt_clr_req && clr_allow;

    pwm_step_timer #(
        .PRESCALE (PRESCALE),
        .CW       (PWM_CODE_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clr     (clr),
        .adv     (adv),
        .nxt     (nxt)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_lane
        localparam int OFF = (PHASE_STEP * (g % PHASE_GROUPS)) % STEPS;
        pwm_lane #(
            .OFFSET (OFF)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .nxt   (nxt),
            .cfg   (port_cfg[g*8 +: 8]),
            .pwm   (pwm_out[g])
        );
    end

    // R9: a clear with the enable low leaves outputs untouched unless a step is due
    a_r9_gated_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_req && !clr_allow && !tick_en) |=> $stable(pwm_out));

endmodule

// File: tb/sim_stagger_pwm.sv
module sim_stagger_pwm;
    localparam int NP = 9;
    localparam int P  = 4;
    localparam int ST = 32;
    localparam int PERIOD_CLK = ST * P;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0;
    logic            cnt_clr_req = 1'b0;
    logic            clr_allow = 1'b0;
    logic [NP*8-1:0] port_cfg = '0;
    logic [NP-1:0]   pwm_out;

    int    vectors = 0;
    int    fails = 0;
    bit    chk_on = 1'b1;
    string focus = "R1";

    int mp = 0;
    int mc = 0;
    int mmode [NP];
    int mduty [NP];
    bit mout  [NP];

    always #2 clk = ~clk;

    stagger_pwm #(
        .NUM_PORTS    (NP),
        .PRESCALE     (P),
        .PHASE_GROUPS (8)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .cnt_clr_req (cnt_clr_req),
        .clr_allow   (clr_allow),
        .port_cfg    (port_cfg),
        .pwm_out     (pwm_out)
    );

    // reference model from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mp = 0;
            mc = 0;
            for (int i = 0; i < NP; i++) begin
                mmode[i] = 0; mduty[i] = 0; mout[i] = 1'b0;
            end
        end else begin
            bit step;
            step = 1'b0;
            if (cnt_clr_req && clr_allow) begin
                mp = 0; mc = 0; step = 1'b1;
            end else if (tick_en) begin
                if (mp == P - 1) begin
                    mp = 0; mc = (mc + 1) % ST; step = 1'b1;
                end else begin
                    mp = mp + 1;
                end
            end
            if (step) begin
                for (int i = 0; i < NP; i++) begin
                    int ph;
                    logic [7:0] w;
                    ph = (mc - 4 * (i % 8) + ST) % ST;
                    w  = port_cfg[i*8 +: 8];
                    if (ph == 0) begin
                        if (w[7:4] == 4'b0111) begin
                            mmode[i] = 1; mduty[i] = 0;
                        end else if (w[4:0] == 5'd0) begin
                            mmode[i] = 0; mduty[i] = 0;
                        end else begin
                            mmode[i] = 2; mduty[i] = int'(w[4:0]);
                        end
                    end
                    if (mmode[i] == 1)      mout[i] = 1'b1;
                    else if (mmode[i] == 2) mout[i] = (ph < mduty[i]);
                    else                    mout[i] = 1'b0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            for (int i = 0; i < NP; i++) begin
                vectors++;
                if (pwm_out[i] !== mout[i]) begin
                    fails++;
                    $display("FAIL %s port %0d at %0t: got %0b expected %0b",
                             focus, i, $time, pwm_out[i], mout[i]);
                end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_all_duty(input int base, input int stride);
        for (int i = 0; i < NP; i++)
            port_cfg[i*8 +: 8] = 8'((base + stride * i) % 32);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        focus = "R1";
        port_cfg = {NP{8'h10}};
        run(5);
        for (int i = 0; i < NP; i++) begin
            vectors++;
            if (pwm_out[i] !== 1'b0) begin
                fails++;
                $display("FAIL R1 port %0d: got %0b expected 0", i, pwm_out[i]);
            end
        end
        rst_n = 1'b1;
        tick_en = 1'b1;
        run(PERIOD_CLK / 2);

        // R5: sweep every duty over all ports
        focus = "R5";
        for (int d = 0; d < 32; d++) begin
            set_all_duty(d, 3);
            run(2 * PERIOD_CLK);
        end

        // R4: duty zero everywhere
        focus = "R4";
        port_cfg = '0;
        run(2 * PERIOD_CLK);

        // R6: all sixteen static-high words
        focus = "R6";
        for (int k = 0; k < 16; k += 2) begin
            for (int i = 0; i < NP; i++)
                port_cfg[i*8 +: 8] = (i % 2 == 0) ? 8'(8'h70 + k + (i % 2)) : 8'(8'h71 + k);
            run(2 * PERIOD_CLK);
        end

        // R10: stray upper bits must not alter the duty
        focus = "R10";
        port_cfg = {8'hE5, 8'h25, 8'h45, 8'hF3, 8'hA0, 8'h3F, 8'h8C, 8'hC1, 8'h6B};
        run(2 * PERIOD_CLK);

        // R2: sparse enable patterns
        focus = "R2";
        set_all_duty(5, 7);
        for (int k = 0; k < 3 * PERIOD_CLK * 3; k++) begin
            tick_en = ((k % 3) != 0) || ((k % 7) == 0);
            run(1);
        end
        tick_en = 1'b1;

        // R3: single-step pulse on each port repeats each period
        focus = "R3";
        port_cfg = {NP{8'h01}};
        run(3 * PERIOD_CLK);

        // R8: rewrites inside the period
        focus = "R8";
        for (int k = 0; k < 60; k++) begin
            set_all_duty(k * 5 + 2, 11);
            if (k % 9 == 4) port_cfg[3*8 +: 8] = 8'h7A;
            run(17 + (k % 13));
        end

        // R9: clear with and without the enable
        focus = "R9";
        set_all_duty(9, 4);
        for (int k = 0; k < 12; k++) begin
            run(23 + 11 * k);
            cnt_clr_req = 1'b1;
            clr_allow = (k % 2 == 1);
            run(1 + (k % 3));
            cnt_clr_req = 1'b0;
            clr_allow = 1'b0;
        end
        run(PERIOD_CLK);

        // R7: stagger with duty 4 gives one group at a time
        focus = "R7";
        port_cfg = {NP{8'h04}};
        run(2 * PERIOD_CLK);
        for (int k = 0; k < 2 * PERIOD_CLK; k++) begin
            int exp_ones;
            run(1);
            exp_ones = (mc < 4) ? 2 : 1;
            vectors++;
            if ($countones(pwm_out) != exp_ones) begin
                fails++;
                $display("FAIL R7 step %0d: got %0d ports high expected %0d",
                         mc, $countones(pwm_out), exp_ones);
            end
        end
        // R11: outputs stay frozen when no enable arrives
        focus = "R11";
        tick_en = 1'b0;
        set_all_duty(17, 3);
        run(PERIOD_CLK);
        tick_en = 1'b1;
        run(PERIOD_CLK);

        finish_run();
    end
endmodule